// File: doc/BRIEF.md
# Serial Transmit Controller with Register Front End

This block is the transmit half of a serial port as software sees it. A small register window, addressed by byte offset on word boundaries, accepts characters, sets up the frame format and the bit rate, and reports line and FIFO state. Characters written to the data register queue in a transmit FIFO. A serializer sends them with a start bit, 5 to 8 data bits LSB first, an optional even or odd parity bit, and one or two stop bits.

Three modem-status inputs are synchronized and shown in the flag register. Any change on them latches a modem interrupt, which software clears by writing the interrupt register. The receive path is not part of this block. Its state arrives as three level inputs: receive request, receive timeout and receive-buffer empty. These inputs are only reported and masked. One interrupt line is the OR of all enabled causes.

Top module: `sertx_regif`

## Requirements
- R1: Register map by byte offset, all cleared by reset: data 0x00 (write only; reads 0), receive status 0x04 (reads 0), line control 0x08, divisor upper byte 0x0C, divisor lower byte 0x10, control 0x14, flags 0x18 (read only), interrupt status 0x1C. Line control, both divisor bytes and control read back what was written.
- R2: The divisor D is {0x0C, 0x10}. Each serial bit lasts 16*(D+1) clock cycles.
- R3: A frame is a low start bit, then the data bits LSB first. The data width is set by line-control bits 6:5: 00 gives 5 bits, 01 gives 6, 10 gives 7 and 11 gives 8. Unused upper bits of the written byte are not sent.
- R4: Line-control bit 1 adds a parity bit after the data. Line-control bit 2 set gives even parity (total ones even); bit 2 clear gives odd parity.
- R5: Line-control bit 3 selects two high stop bits instead of one.
- R6: The transmit FIFO holds 16 characters. Flag bit 5 is high when it is full. A data write while it is full is dropped.
- R7: When line-control bit 4 is clear, the FIFO holds a single character and reports full after one write.
- R8: Characters leave the FIFO only while control bit 0 is set. Interrupt bit 2 is high when control bits 0 and 5 are set and the FIFO holds 8 or fewer characters.
- R9: While line-control bit 0 is set, the serial output is held low. When the bit is cleared, the output returns high.
- R10: Flag bits 0, 1 and 2 show the synchronized CTS, DSR and DCD inputs. Flag bit 4 shows the receive-empty input. Flag bit 7 is high only when the FIFO is empty and no frame is being sent. The idle line is high.
- R11: A change on any synchronized modem input latches a modem event. The event stays latched until any write to 0x1C. Interrupt bit 0 shows the event masked by control bit 3.
- R12: Interrupt bit 1 is the receive request, masked by control bits 0 and 4. Interrupt bit 3 is the receive timeout, masked by control bits 0 and 6. The interrupt output is high when any interrupt-status bit is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWr | input | 1 | Register write strobe |
| regAddr | input | 5 | Byte address of the register |
| regWdata | input | 8 | Write data |
| regRdata | output | 8 | Read data, combinational from regAddr |
| ctsIn | input | 1 | Clear-to-send input, asynchronous |
| dsrIn | input | 1 | Data-set-ready input, asynchronous |
| dcdIn | input | 1 | Carrier-detect input, asynchronous |
| rxReqIn | input | 1 | Receive interrupt request from the receive path |
| rxTimeoutIn | input | 1 | Receive-timeout request from the receive path |
| rxEmptyIn | input | 1 | Receive buffer empty from the receive path |
| txOut | output | 1 | Serial output |
| irqOut | output | 1 | Combined interrupt |

## Verification
A data write that lands on a clock edge enters the FIFO at that edge. When the serializer is idle and enabled, the start bit begins on the next edge. Every later bit boundary falls a whole multiple of 16*(D+1) cycles after that edge. The scoreboard monitor therefore waits for the falling start edge and samples each bit at its middle, so the check does not depend on exact edge alignment. Register reads are combinational and are sampled half a cycle after the address settles. Modem inputs appear in the flags two edges after they change and latch the event one edge later, so the bench waits four cycles before it reads them. Mask and receive-request effects appear in the same cycle and are read on the next falling edge.

// File: rtl/sertx_pkg.sv
package sertx_pkg;
  localparam int DIV_W     = 16;
  localparam int OVERSAMP  = 16;
  localparam int SUB_W     = $clog2(OVERSAMP);
  localparam int FRAME_W   = 12;
  localparam int LEN_W     = $clog2(FRAME_W + 1);
  localparam int ADDR_W    = 5;

  typedef enum logic [2:0] {
    RG_DATA = 3'd0, RG_RXST = 3'd1, RG_LINE = 3'd2, RG_DIVH = 3'd3,
    RG_DIVL = 3'd4, RG_CTRL = 3'd5, RG_FLAG = 3'd6, RG_IRQ  = 3'd7
  } regIdxT;

  // strobes and settings from control to datapath
  typedef struct packed {
    logic             push;
    logic [7:0]       pushData;
    logic             enable;
    logic             fifoOn;
    logic             brk;
    logic             parOn;
    logic             parEven;
    logic             twoStop;
    logic [1:0]       wordSel;
    logic [DIV_W-1:0] divisor;
  } txCtlT;

  // state from datapath back to control
  typedef struct packed {
    logic full;
    logic empty;
    logic lowWater;
    logic active;
  } txStatT;
endpackage

// File: rtl/sertx_datapath.sv
module sertx_datapath
  import sertx_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic   clk,
  input  logic   rstN,
  input  txCtlT  cfg,
  output txStatT status,
  output logic   txOut
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam int HALF  = DEPTH / 2;

  logic [7:0]         mem [DEPTH];
  logic [PTR_W-1:0]   wrPtr, rdPtr;
  logic [CNT_W-1:0]   count, capLimit;
  logic               full, doPush, doPop, active;
  logic [FRAME_W-1:0] shiftReg, frame;
  logic [LEN_W-1:0]   bitsLeft, frameLen;
  logic [SUB_W-1:0]   subTick;
  logic [DIV_W-1:0]   divCnt;
  logic [3:0]         nBits;
  logic [7:0]         word, masked;
  logic               parBit;

  assign capLimit = cfg.fifoOn ? CNT_W'(DEPTH) : CNT_W'(1);
  assign full     = (count >= capLimit);
  assign doPush   = cfg.push && !full;
  assign doPop    = cfg.enable && !active && (count != '0);

  function automatic logic [PTR_W-1:0] nextPtr(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (doPush) mem[wrPtr] <= cfg.pushData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (doPush) wrPtr <= nextPtr(wrPtr);
      if (doPop)  rdPtr <= nextPtr(rdPtr);
      case ({doPush, doPop})
        2'b10:   count <= count + CNT_W'(1);
        2'b01:   count <= count - CNT_W'(1);
        default: count <= count;
      endcase
    end
  end

  // frame assembly for the character at the FIFO head
  always_comb begin
    nBits  = 4'd5 + {2'b00, cfg.wordSel};
    word   = mem[rdPtr];
    masked = '0;
    for (int i = 0; i < 8; i++)
      if (4'(i) < nBits) masked[i] = word[i];
    parBit = cfg.parEven ? ^masked : ~^masked;
    frame    = '1;
    frame[0] = 1'b0;
    for (int i = 0; i < 8; i++)
      if (4'(i) < nBits) frame[1 + i] = masked[i];
    if (cfg.parOn) frame[4'd1 + nBits] = parBit;
    frameLen = LEN_W'(4'd2 + nBits + {3'b000, cfg.parOn} + {3'b000, cfg.twoStop});
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      active   <= 1'b0;
      shiftReg <= '1;
      bitsLeft <= '0;
      subTick  <= '0;
      divCnt   <= '0;
    end else if (doPop) begin
      active   <= 1'b1;
      shiftReg <= frame;
      bitsLeft <= frameLen;
      subTick  <= '0;
      divCnt   <= cfg.divisor;
    end else if (active) begin
      if (divCnt == '0) begin
        divCnt  <= cfg.divisor;
        subTick <= subTick + SUB_W'(1);
        if (subTick == SUB_W'(OVERSAMP - 1)) begin
          shiftReg <= {1'b1, shiftReg[FRAME_W-1:1]};
          bitsLeft <= bitsLeft - LEN_W'(1);
          if (bitsLeft == LEN_W'(1)) active <= 1'b0;
        end
      end else begin
        divCnt <= divCnt - DIV_W'(1);
      end
    end
  end

  assign txOut           = cfg.brk ? 1'b0 : (active ? shiftReg[0] : 1'b1);
  assign status.full     = full;
  assign status.empty    = (count == '0);
  assign status.lowWater = (count <= CNT_W'(HALF));
  assign status.active   = active;
endmodule

// File: rtl/sertx_ctrl.sv
module sertx_ctrl
  import sertx_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWr,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [7:0]        regWdata,
  output logic [7:0]        regRdata,
  input  logic              ctsIn,
  input  logic              dsrIn,
  input  logic              dcdIn,
  input  logic              rxReqIn,
  input  logic              rxTimeoutIn,
  input  logic              rxEmptyIn,
  input  txStatT            status,
  output txCtlT             cfg,
  output logic              irqOut
);
  localparam int HI_W = DIV_W - 8;

  logic [7:0]      lineReg, ctlReg, flagVec, irqVec;
  logic [HI_W-1:0] divHi;
  logic [7:0]      divLo;
  logic [2:0]      mdmMeta, mdmSync, mdmPrev;
  logic            mdmLatch, aligned, drained;
  regIdxT          idx;

  assign aligned = (regAddr[1:0] == 2'b00);
  assign idx     = regIdxT'(regAddr[4:2]);

  function automatic logic hitWr(input regIdxT r);
    return regWr && aligned && (idx == r);
  endfunction

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lineReg <= '0;
      ctlReg  <= '0;
      divHi   <= '0;
      divLo   <= '0;
    end else begin
      if (hitWr(RG_LINE)) lineReg <= regWdata;
      if (hitWr(RG_CTRL)) ctlReg  <= regWdata;
      if (hitWr(RG_DIVH)) divHi   <= regWdata[HI_W-1:0];
      if (hitWr(RG_DIVL)) divLo   <= regWdata;
    end
  end

  // modem inputs: two-flop synchronizer plus change latch
  always_ff @(posedge clk) begin
    if (!rstN) begin
      mdmMeta  <= '0;
      mdmSync  <= '0;
      mdmPrev  <= '0;
      mdmLatch <= 1'b0;
    end else begin
      mdmMeta <= {dcdIn, dsrIn, ctsIn};
      mdmSync <= mdmMeta;
      mdmPrev <= mdmSync;
      if (mdmSync != mdmPrev)  mdmLatch <= 1'b1;
      else if (hitWr(RG_IRQ))  mdmLatch <= 1'b0;
    end
  end

  assign drained = status.empty && !status.active;
  assign flagVec = {drained, 1'b0, status.full, rxEmptyIn, 1'b0, mdmSync};
  assign irqVec  = {4'b0000,
                    rxTimeoutIn     && ctlReg[0] && ctlReg[6],
                    status.lowWater && ctlReg[0] && ctlReg[5],
                    rxReqIn         && ctlReg[0] && ctlReg[4],
                    mdmLatch        && ctlReg[3]};
  assign irqOut  = |irqVec;

  always_comb begin
    regRdata = '0;
    if (aligned) begin
      case (idx)
        RG_LINE: regRdata = lineReg;
        RG_DIVH: regRdata = 8'(divHi);
        RG_DIVL: regRdata = divLo;
        RG_CTRL: regRdata = ctlReg;
        RG_FLAG: regRdata = flagVec;
        RG_IRQ:  regRdata = irqVec;
        default: regRdata = '0;
      endcase
    end
  end

  assign cfg.push     = hitWr(RG_DATA);
  assign cfg.pushData = regWdata;
  assign cfg.enable   = ctlReg[0];
  assign cfg.brk      = lineReg[0];
  assign cfg.parOn    = lineReg[1];
  assign cfg.parEven  = lineReg[2];
  assign cfg.twoStop  = lineReg[3];
  assign cfg.fifoOn   = lineReg[4];
  assign cfg.wordSel  = lineReg[6:5];
  assign cfg.divisor  = {divHi, divLo};
endmodule

// File: rtl/sertx_regif.sv
module sertx_regif
  import sertx_pkg::*;
#(
  parameter int FIFO_DEPTH = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWr,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [7:0]        regWdata,
  output logic [7:0]        regRdata,
  input  logic              ctsIn,
  input  logic              dsrIn,
  input  logic              dcdIn,
  input  logic              rxReqIn,
  input  logic              rxTimeoutIn,
  input  logic              rxEmptyIn,
  output logic              txOut,
  output logic              irqOut
);
  txCtlT  cfgBus;
  txStatT statBus;

  sertx_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .ctsIn(ctsIn),
    .dsrIn(dsrIn), .dcdIn(dcdIn), .rxReqIn(rxReqIn),
    .rxTimeoutIn(rxTimeoutIn), .rxEmptyIn(rxEmptyIn),
    .status(statBus), .cfg(cfgBus), .irqOut(irqOut)
  );

  sertx_datapath #(.DEPTH(FIFO_DEPTH)) dp_i (
    .clk(clk), .rstN(rstN), .cfg(cfgBus), .status(statBus), .txOut(txOut)
  );
endmodule

// File: rtl/sertx_checker.sv
module sertx_checker
  import sertx_pkg::*;
(
  input logic   clk,
  input logic   rstN,
  input txCtlT  cfg,
  input txStatT status,
  input logic   txOut
);
  // R9: break forces the line low
  p_break_low_r9: assert property (@(posedge clk) disable iff (!rstN)
    cfg.brk |-> !txOut);

  // R10: idle serializer leaves the line high
  p_idle_high_r10: assert property (@(posedge clk) disable iff (!rstN)
    (!status.active && !cfg.brk) |-> txOut);

  // R8: a frame only starts while enabled
  p_start_enabled_r8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(status.active) |-> $past(cfg.enable));

  // R6: a write into a full, stalled FIFO leaves it full
  p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rstN)
    (cfg.push && status.full && !cfg.enable) |=> status.full);

  // R6: full and empty never coincide
  p_full_not_empty_r6: assert property (@(posedge clk) disable iff (!rstN)
    !(status.full && status.empty));
endmodule

bind sertx_regif sertx_checker chk_i (
  .clk(clk), .rstN(rstN), .cfg(cfgBus), .status(statBus), .txOut(txOut)
);

// File: tb/sertx_regif_tb_top.sv
module sertx_regif_tb_top;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       regWr = 1'b0;
  logic [4:0] regAddr = '0;
  logic [7:0] regWdata = '0;
  logic [7:0] regRdata;
  logic       ctsIn = 0, dsrIn = 0, dcdIn = 0;
  logic       rxReqIn = 0, rxTimeoutIn = 0, rxEmptyIn = 1;
  logic       txOut, irqOut;

  int checks = 0, fails = 0, frames = 0, bitClks = 16;
  bit monEn = 1'b1, monBusy = 1'b0, done = 1'b0;
  int curBits = 8; bit curPar = 0, curEven = 0, curTwo = 0;
  logic [15:0] expQ [$];

  always #5 clk = ~clk;

  sertx_regif dut_i (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .ctsIn(ctsIn), .dsrIn(dsrIn),
    .dcdIn(dcdIn), .rxReqIn(rxReqIn), .rxTimeoutIn(rxTimeoutIn),
    .rxEmptyIn(rxEmptyIn), .txOut(txOut), .irqOut(irqOut)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wrReg(input logic [4:0] a, input logic [7:0] d);
    @(negedge clk); regWr = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk); regWr = 1'b0;
  endtask

  task automatic rdReg(input logic [4:0] a, output logic [7:0] d);
    @(negedge clk); regAddr = a; #1; d = regRdata;
  endtask

  task automatic setLine(input int bits, input bit par, input bit even, input bit two);
    curBits = bits; curPar = par; curEven = even; curTwo = two;
    wrReg(5'h08, {1'b0, 2'(bits - 5), 1'b1, two, even, par, 1'b0});
  endtask

  task automatic sendByte(input logic [7:0] d);
    expQ.push_back({3'b000, curTwo, curEven, curPar, 2'(curBits - 5), d});
    wrReg(5'h00, d);
  endtask

  task automatic waitDrain();
    logic [7:0] f;
    for (int n = 0; n < 20000; n++) begin
      rdReg(5'h18, f);
      if (f[7] && expQ.size() == 0 && !monBusy) break;
    end
    chk("R6 drain queue empty", expQ.size(), 0);
  endtask

  // scoreboard monitor: decode each frame at bit centres
  task automatic decodeFrame();
    logic [15:0] e;
    logic [7:0]  got, mask;
    int nb;
    bit p;
    monBusy = 1'b1;
    if (expQ.size() == 0) begin
      chk("R3 unexpected frame", 1, 0);
      while (txOut === 1'b0) @(negedge clk);
      monBusy = 1'b0;
      return;
    end
    e = expQ.pop_front();
    nb = int'(e[9:8]) + 5;
    mask = 8'((1 << nb) - 1);
    got = '0;
    repeat (bitClks / 2) @(negedge clk);
    chk("R2 start bit low at centre", txOut, 0);
    for (int i = 0; i < nb; i++) begin
      repeat (bitClks) @(negedge clk);
      got[i] = txOut;
    end
    chk("R3 R2 data bits", got, e[7:0] & mask);
    if (e[10]) begin
      repeat (bitClks) @(negedge clk);
      p = e[11] ? ^(e[7:0] & mask) : ~^(e[7:0] & mask);
      chk("R4 parity bit", txOut, p);
    end
    repeat (bitClks) @(negedge clk);
    chk("R5 first stop bit", txOut, 1);
    if (e[12]) begin
      repeat (bitClks) @(negedge clk);
      chk("R5 second stop bit", txOut, 1);
    end
    frames++;
    monBusy = 1'b0;
  endtask

  initial begin
    forever begin
      @(negedge clk);
      if (monEn && rstN && txOut === 1'b0) decodeFrame();
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] r;
    int f0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // reset state
    rdReg(5'h18, r); chk("R10 R1 flags after reset", r, 8'h90);
    rdReg(5'h1C, r); chk("R1 irq status after reset", r, 0);
    chk("R10 idle line high", txOut, 1);
    chk("R12 no interrupt after reset", irqOut, 0);

    // register readback
    wrReg(5'h0C, 8'hAB); rdReg(5'h0C, r); chk("R1 divisor upper readback", r, 8'hAB);
    wrReg(5'h0C, 8'h00); wrReg(5'h10, 8'h00);
    wrReg(5'h14, 8'h01); rdReg(5'h14, r); chk("R1 control readback", r, 8'h01);
    setLine(8, 0, 0, 0); rdReg(5'h08, r); chk("R1 line control readback", r, 8'h70);
    rdReg(5'h04, r); chk("R1 receive status reads zero", r, 0);

    // 8N1, divisor 0
    sendByte(8'hA5);
    rdReg(5'h18, r); chk("R10 empty flag low while sending", r[7], 0);
    sendByte(8'h3C);
    waitDrain();

    // parity, 7 bits even then 8 bits odd
    setLine(7, 1, 1, 0); sendByte(8'h55); sendByte(8'h13);
    waitDrain();
    setLine(8, 1, 0, 0); sendByte(8'hC1); sendByte(8'h00);
    waitDrain();

    // two stop bits back to back, then 5 and 6 bit words
    setLine(8, 0, 0, 1); sendByte(8'hFE); sendByte(8'h01); sendByte(8'h80);
    waitDrain();
    setLine(5, 0, 0, 0); sendByte(8'hFF); sendByte(8'hEA);
    waitDrain();
    setLine(6, 1, 1, 1); sendByte(8'hB7);
    waitDrain();

    // bit period with divisor 1
    setLine(8, 0, 0, 0);
    wrReg(5'h10, 8'h01); bitClks = 32;
    rdReg(5'h10, r); chk("R1 divisor lower readback", r, 8'h01);
    sendByte(8'h96); sendByte(8'h0F);
    waitDrain();
    wrReg(5'h10, 8'h00); bitClks = 16;

    // fill FIFO with transmitter disabled
    wrReg(5'h14, 8'h20);
    f0 = frames;
    for (int i = 0; i < 16; i++) sendByte(8'(i * 17 + 3));
    wrReg(5'h00, 8'h77);
    rdReg(5'h18, r); chk("R6 full flag after 17 writes", r[5], 1);
    repeat (50) @(negedge clk);
    chk("R8 nothing sent while disabled", frames - f0, 0);
    chk("R8 line idle while disabled", txOut, 1);
    rdReg(5'h1C, r); chk("R8 tx interrupt gated by enable", r[2], 0);
    wrReg(5'h14, 8'h21);
    rdReg(5'h1C, r); chk("R8 tx interrupt off above half", r[2], 0);
    for (int n = 0; n < 20000 && irqOut !== 1'b1; n++) @(negedge clk);
    rdReg(5'h1C, r); chk("R8 tx interrupt at half level", r, 8'h04);
    waitDrain();
    chk("R6 sixteen frames, extra write dropped", frames - f0, 16);

    // single-entry mode
    wrReg(5'h14, 8'h00);
    wrReg(5'h08, 8'h60); curBits = 8; curPar = 0; curEven = 0; curTwo = 0;
    f0 = frames;
    sendByte(8'h5A);
    rdReg(5'h18, r); chk("R7 full after one write", r[5], 1);
    wrReg(5'h00, 8'hA5);
    wrReg(5'h14, 8'h01);
    waitDrain();
    chk("R7 only one frame sent", frames - f0, 1);

    // break
    setLine(8, 0, 0, 0);
    monEn = 1'b0;
    wrReg(5'h08, 8'h71);
    repeat (20) @(negedge clk);
    chk("R9 line low during break", txOut, 0);
    wrReg(5'h08, 8'h70);
    @(negedge clk);
    chk("R9 line high after break", txOut, 1);
    monEn = 1'b1;

    // modem status
    wrReg(5'h14, 8'h09);
    @(negedge clk); ctsIn = 1'b1;
    repeat (4) @(negedge clk);
    rdReg(5'h18, r); chk("R10 CTS flag", r[2:0], 3'b001);
    rdReg(5'h1C, r); chk("R11 modem event latched", r, 8'h01);
    chk("R11 interrupt output on modem event", irqOut, 1);
    wrReg(5'h1C, 8'h00);
    rdReg(5'h1C, r); chk("R11 modem event cleared by write", r, 8'h00);
    chk("R11 interrupt output cleared", irqOut, 0);
    wrReg(5'h14, 8'h01);
    @(negedge clk); dcdIn = 1'b1;
    repeat (4) @(negedge clk);
    rdReg(5'h1C, r); chk("R11 masked modem event hidden", r, 8'h00);
    chk("R11 masked event no interrupt", irqOut, 0);
    wrReg(5'h14, 8'h09);
    rdReg(5'h1C, r); chk("R11 event held while masked", r, 8'h01);
    wrReg(5'h1C, 8'h00);

    // receive-side causes
    wrReg(5'h14, 8'h51);
    @(negedge clk); rxReqIn = 1'b1;
    rdReg(5'h1C, r); chk("R12 receive request bit", r, 8'h02);
    rxTimeoutIn = 1'b1;
    rdReg(5'h1C, r); chk("R12 receive timeout bit", r, 8'h0A);
    chk("R12 interrupt output", irqOut, 1);
    wrReg(5'h14, 8'h01);
    rdReg(5'h1C, r); chk("R12 receive causes masked", r, 8'h00);
    chk("R12 interrupt output masked", irqOut, 0);
    rxEmptyIn = 1'b0;
    rdReg(5'h18, r); chk("R10 receive empty flag", r[4], 0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule